// File: doc/BRIEF.md
# Gamma-Corrected Fade PWM Engine

This block drives a lamp gate with a fixed-frequency pulse-width modulated signal whose duty follows a 63-point perceptual (gamma) curve. When the on-request input goes high, the engine walks its step index upward one point at a time until it reaches the top step. When the request goes low, it walks back down to step zero. The duty at each step comes from a built-in curve that runs from 0 to 1000 parts per thousand.

The fade-in and fade-out durations are set independently by two 8-bit time codes. Each code unit is one 63rd of a 7 ms slice of total ramp time per step, so a code of N gives a total ramp of about N × 7 ms. A code of zero, or the instant input, makes the output jump straight to the end step. A request that changes in the middle of a ramp turns the ramp around at the step it has reached. One instance can drive several current channels in parallel. Upstream logic is expected to debounce the request.

Top module: `gamma_fade_pwm`

## Requirements
- R1: While reset is asserted, and after it is released with no request, `step_idx` is 0 and `pwm_out` is low. Asserting reset in the middle of a ramp returns both outputs to that state.
- R2: `step_idx` never exceeds 62. It stays at 62 while the request is held high and at 0 while it is held low, with no further movement.
- R3: With `up_time` = U ≠ 0 and `instant` low, a rising request moves the index up by one every U × STEP_TICKS clocks. The index reaches 62 from 0 on the (1 + 62·U·STEP_TICKS)-th rising clock edge after the request changes.
- R4: With `dn_time` = D ≠ 0 and `instant` low, a falling request moves the index down by one every D × STEP_TICKS clocks. The index reaches 0 from 62 on the (1 + 62·D·STEP_TICKS)-th edge.
- R5: A time code of 0 for the active direction moves the index to its end step (62 for on, 0 for off) on the first rising edge after the request changes.
- R6: With `instant` high, both directions behave as in R5, whatever the time codes are.
- R7: Changing the request mid-ramp reverses the direction from the current step without a jump. The index holds for one edge and then moves one step after one full dwell of the new direction.
- R8: The PWM period is 1000 × PWM_DIV clocks. Within each period `pwm_out` is high for duty(step_idx) counts, where duty(0) = 0, duty(1) = 2, duty(62) = 1000, and the curve is non-decreasing.
- R9: While the request is high the index never decreases; while it is low the index never increases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| on_req | input | 1 | Requested state: 1 = fade on, 0 = fade off |
| up_time | input | 8 | Fade-on time code (0 = no fade) |
| dn_time | input | 8 | Fade-off time code (0 = no fade) |
| instant | input | 1 | Forces immediate on/off in both directions |
| pwm_out | output | 1 | PWM gate |
| step_idx | output | 6 | Current gamma step, 0 to 62 |

## Verification
The bound checker watches four properties on every cycle:
- the index stays within range;
- the index moves at most one step per edge while both time codes are non-zero and instant mode is off;
- the index moves only in the requested direction;
- the gate never rises at step 0 and never falls at step 62.

Other behaviours can only be shown by the bench scenarios, because they depend on exact counts and waveforms:
- the exact ramp lengths for each time code;
- the one-edge jump for zero codes and for instant mode;
- the point where a reversed ramp turns around;
- the high-time count within a PWM period at an intermediate step.

// File: rtl/gf_pkg.sv
package gf_pkg;
  localparam int GF_STEPS = 63;
  localparam int GF_LAST  = GF_STEPS - 1;
  localparam int GF_FULL  = 1000;
  localparam int GF_SW    = $clog2(GF_STEPS);
  localparam int GF_DW    = $clog2(GF_FULL + 1);

  typedef logic [GF_SW-1:0] step_t;
  typedef logic [GF_DW-1:0] duty_t;

  // Perceptual curve, parts per thousand per step
  function automatic duty_t gf_curve(input step_t s);
    case (s)
      6'd0:  return 10'd0;    6'd1:  return 10'd2;    6'd2:  return 10'd4;
      6'd3:  return 10'd6;    6'd4:  return 10'd8;    6'd5:  return 10'd10;
      6'd6:  return 10'd12;   6'd7:  return 10'd16;   6'd8:  return 10'd20;
      6'd9:  return 10'd24;   6'd10: return 10'd28;   6'd11: return 10'd32;
      6'd12: return 10'd36;   6'd13: return 10'd42;   6'd14: return 10'd48;
      6'd15: return 10'd54;   6'd16: return 10'd60;   6'd17: return 10'd66;
      6'd18: return 10'd72;   6'd19: return 10'd80;   6'd20: return 10'd88;
      6'd21: return 10'd96;   6'd22: return 10'd104;  6'd23: return 10'd112;
      6'd24: return 10'd120;  6'd25: return 10'd130;  6'd26: return 10'd140;
      6'd27: return 10'd150;  6'd28: return 10'd160;  6'd29: return 10'd170;
      6'd30: return 10'd180;  6'd31: return 10'd194;  6'd32: return 10'd208;
      6'd33: return 10'd222;  6'd34: return 10'd236;  6'd35: return 10'd250;
      6'd36: return 10'd264;  6'd37: return 10'd282;  6'd38: return 10'd300;
      6'd39: return 10'd318;  6'd40: return 10'd336;  6'd41: return 10'd354;
      6'd42: return 10'd372;  6'd43: return 10'd394;  6'd44: return 10'd416;
      6'd45: return 10'd438;  6'd46: return 10'd460;  6'd47: return 10'd482;
      6'd48: return 10'd504;  6'd49: return 10'd534;  6'd50: return 10'd564;
      6'd51: return 10'd594;  6'd52: return 10'd624;  6'd53: return 10'd654;
      6'd54: return 10'd684;  6'd55: return 10'd722;  6'd56: return 10'd760;
      6'd57: return 10'd798;  6'd58: return 10'd836;  6'd59: return 10'd874;
      6'd60: return 10'd914;  6'd61: return 10'd956;  6'd62: return 10'd1000;
      default: return 10'd0;
    endcase
  endfunction
endpackage

// File: rtl/gf_step_seq.sv
module gf_step_seq
  import gf_pkg::*;
#(
  parameter int STEP_TICKS = 1111
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       on_req,
  input  logic [7:0] up_time,
  input  logic [7:0] dn_time,
  input  logic       instant,
  output step_t      step_idx
);
  localparam int    TW       = 8 + $clog2(STEP_TICKS + 1);
  localparam step_t LAST_IDX = step_t'(GF_LAST);

  logic [TW-1:0] tmr_q, tmr_d, dwell;
  step_t         idx_q, idx_d;
  logic          req_q;
  logic [7:0]    sel_time;
  logic          at_end, fast;

  always_comb begin
    sel_time = on_req ? up_time : dn_time;
    dwell    = TW'(sel_time) * TW'(STEP_TICKS);
    at_end   = on_req ? (idx_q == LAST_IDX) : (idx_q == '0);
    fast     = instant || (sel_time == 8'd0);
    idx_d    = idx_q;
    tmr_d    = tmr_q;
    if (at_end) begin
      tmr_d = '0;
    end else if (fast) begin
      idx_d = on_req ? LAST_IDX : '0;
      tmr_d = '0;
    end else if (on_req != req_q) begin
      tmr_d = '0;                       // direction change restarts dwell
    end else if (tmr_q == dwell - TW'(1)) begin
      tmr_d = '0;
      idx_d = on_req ? idx_q + step_t'(1) : idx_q - step_t'(1);
    end else begin
      tmr_d = tmr_q + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
      idx_q <= '0;
      req_q <= 1'b0;
    end else begin
      tmr_q <= tmr_d;
      idx_q <= idx_d;
      req_q <= on_req;
    end
  end

  assign step_idx = idx_q;
endmodule

// File: rtl/gf_curve_lut.sv
module gf_curve_lut
  import gf_pkg::*;
(
  input  step_t step_idx,
  output duty_t duty
);
  assign duty = gf_curve(step_idx);
endmodule

// File: rtl/gf_pwm_gen.sv
module gf_pwm_gen
  import gf_pkg::*;
#(
  parameter int PWM_DIV = 45
) (
  input  logic  clk,
  input  logic  rst_n,
  input  duty_t duty,
  output logic  pwm_out
);
  localparam int    DW      = (PWM_DIV > 1) ? $clog2(PWM_DIV) : 1;
  localparam duty_t CNT_TOP = duty_t'(GF_FULL - 1);

  logic  tick;
  duty_t cnt_q, cnt_d;
  logic  pwm_q, pwm_d;

  generate
    if (PWM_DIV > 1) begin : g_div
      logic [DW-1:0] div_q, div_d;
      always_comb begin
        tick  = (div_q == DW'(PWM_DIV - 1));
        div_d = tick ? '0 : div_q + DW'(1);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
      end
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  always_comb begin
    cnt_d = cnt_q;
    pwm_d = pwm_q;
    if (tick) begin
      cnt_d = (cnt_q == CNT_TOP) ? '0 : cnt_q + duty_t'(1);
      pwm_d = (cnt_q < duty);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pwm_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pwm_q <= pwm_d;
    end
  end

  assign pwm_out = pwm_q;
endmodule

// File: rtl/gamma_fade_pwm.sv
module gamma_fade_pwm
  import gf_pkg::*;
#(
  parameter int STEP_TICKS = 1111,
  parameter int PWM_DIV    = 45
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       on_req,
  input  logic [7:0] up_time,
  input  logic [7:0] dn_time,
  input  logic       instant,
  output logic       pwm_out,
  output logic [5:0] step_idx
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  step_t      idx;
  duty_t      duty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  gf_step_seq #(.STEP_TICKS(STEP_TICKS)) u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .on_req   (on_req),
    .up_time  (up_time),
    .dn_time  (dn_time),
    .instant  (instant),
    .step_idx (idx)
  );

  gf_curve_lut u_lut (
    .step_idx (idx),
    .duty     (duty)
  );

  gf_pwm_gen #(.PWM_DIV(PWM_DIV)) u_pwm (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .duty    (duty),
    .pwm_out (pwm_out)
  );

  assign step_idx = idx;
endmodule

// File: rtl/gf_checker.sv
module gf_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       on_req,
  input logic       instant,
  input logic [7:0] up_time,
  input logic [7:0] dn_time,
  input logic       pwm_out,
  input logic [5:0] step_idx
);
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    step_idx <= 6'd62); // R2

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!instant && up_time != 8'd0 && dn_time != 8'd0) |=>
      ((step_idx == $past(step_idx)) ||
       ({1'b0, step_idx} == {1'b0, $past(step_idx)} + 7'd1) ||
       ({1'b0, step_idx} + 7'd1 == {1'b0, $past(step_idx)}))); // R3

  AST_UP_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    on_req |=> step_idx >= $past(step_idx)); // R9

  AST_DN_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    !on_req |=> step_idx <= $past(step_idx)); // R9

  AST_NO_RISE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_out) |-> $past(step_idx) != 6'd0); // R8

  AST_NO_FALL_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwm_out) |-> $past(step_idx) != 6'd62); // R8
endmodule

bind gamma_fade_pwm gf_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .on_req   (on_req),
  .instant  (instant),
  .up_time  (up_time),
  .dn_time  (dn_time),
  .pwm_out  (pwm_out),
  .step_idx (step_idx)
);

// File: tb/gamma_fade_pwm_tb.sv
module gamma_fade_pwm_tb;
  localparam int ST = 8;
  localparam int PD = 1;
  localparam int NV = 6;
  // {up_time, dn_time}
  localparam logic [7:0] VEC [NV][2] = '{
    '{8'd3, 8'd5}, '{8'd1, 8'd1}, '{8'd0, 8'd4},
    '{8'd7, 8'd0}, '{8'd2, 8'd9}, '{8'd0, 8'd0}};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       on_req = 1'b0;
  logic [7:0] up_time = 8'd0;
  logic [7:0] dn_time = 8'd0;
  logic       instant = 1'b0;
  logic       pwm_out;
  logic [5:0] step_idx;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;

  gamma_fade_pwm #(.STEP_TICKS(ST), .PWM_DIV(PD)) u_dut (
    .clk(clk), .rst_n(rst_n), .on_req(on_req), .up_time(up_time),
    .dn_time(dn_time), .instant(instant), .pwm_out(pwm_out),
    .step_idx(step_idx));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      n_chk++; n_err++;
      $display("FAIL R3 watchdog expired act=%0d exp<190000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // Change request at a falling edge, count rising edges until target step
  task automatic ramp(input logic dir, input int target, output int edges, output int back);
    int prev;
    prev  = step_idx;
    back  = 0;
    edges = 0;
    on_req = dir;
    while (step_idx != 6'(target) && edges < 20000) begin
      @(posedge clk); @(negedge clk);
      edges++;
      if (dir && step_idx < prev)  back++;
      if (!dir && step_idx > prev) back++;
      prev = step_idx;
    end
  endtask

  task automatic count_high(output int highs);
    highs = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (pwm_out) highs++;
    end
  endtask

  initial begin
    int e, b, h, exp;
    @(negedge clk); @(negedge clk);
    check(step_idx == 0 && pwm_out == 1'b0, "R1 reset state", step_idx, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(step_idx == 0 && pwm_out == 1'b0, "R1 after release", step_idx, 0);

    for (int v = 0; v < NV; v++) begin
      up_time = VEC[v][0];
      dn_time = VEC[v][1];
      ramp(1'b1, 62, e, b);
      exp = (VEC[v][0] == 0) ? 1 : 1 + 62 * VEC[v][0] * ST;
      check(e == exp, (VEC[v][0] == 0) ? "R5 zero up" : "R3 up ramp", e, exp);
      check(b == 0, "R9 up monotonic", b, 0);
      repeat (40) @(negedge clk);
      check(step_idx == 6'd62, "R2 hold top", step_idx, 62);
      if (v == 0) begin
        count_high(h);
        check(h == 1000, "R8 duty at top", h, 1000);
      end
      ramp(1'b0, 0, e, b);
      exp = (VEC[v][1] == 0) ? 1 : 1 + 62 * VEC[v][1] * ST;
      check(e == exp, (VEC[v][1] == 0) ? "R5 zero down" : "R4 down ramp", e, exp);
      check(b == 0, "R9 down monotonic", b, 0);
      repeat (40) @(negedge clk);
      check(step_idx == 6'd0, "R2 hold zero", step_idx, 0);
      if (v == 0) begin
        count_high(h);
        check(h == 0, "R8 duty at zero", h, 0);
      end
    end

    // R6 instant mode overrides long codes
    up_time = 8'd200; dn_time = 8'd200; instant = 1'b1;
    ramp(1'b1, 62, e, b);
    check(e == 1, "R6 instant on", e, 1);
    ramp(1'b0, 0, e, b);
    check(e == 1, "R6 instant off", e, 1);
    instant = 1'b0;

    // R7 reversal mid-ramp
    up_time = 8'd2; dn_time = 8'd3;
    ramp(1'b1, 10, e, b);
    check(e == 1 + 10 * 2 * ST, "R7 reach step 10", e, 1 + 10 * 2 * ST);
    on_req = 1'b0;
    @(posedge clk); @(negedge clk);
    check(step_idx == 6'd10, "R7 no jump on reverse", step_idx, 10);
    ramp(1'b0, 9, e, b);
    check(e + 1 == 1 + 3 * ST, "R7 down dwell after reverse", e + 1, 1 + 3 * ST);
    ramp(1'b1, 10, e, b);
    check(e == 1 + 2 * ST, "R7 up dwell after second reverse", e, 1 + 2 * ST);
    instant = 1'b1;
    ramp(1'b0, 0, e, b);
    instant = 1'b0;

    // R8 intermediate duty at step 1
    up_time = 8'd255;
    ramp(1'b1, 1, e, b);
    check(e == 1 + 255 * ST, "R3 first step long code", e, 1 + 255 * ST);
    repeat (2) @(negedge clk);
    count_high(h);
    check(h == 2, "R8 duty at step 1", h, 2);
    check(step_idx == 6'd1, "R3 still step 1", step_idx, 1);

    // R1 reset mid-ramp
    rst_n = 1'b0;
    @(negedge clk);
    check(step_idx == 0 && pwm_out == 1'b0, "R1 reset mid ramp", step_idx, 0);
    on_req = 1'b0;
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(step_idx == 0, "R1 idle after reset", step_idx, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule